// File: doc/BRIEF.md
# Coded-Ratio Clock Divider Bank

A bank of five programmable clock dividers that all run from one fast input clock. Software picks each divider's ratio with a 4-bit code. The codes select from a fixed table of mostly non-power-of-two ratios. Two of the sixteen codes are reserved, and each output also carries its own mask of the codes it accepts.

Code writes go into a staging register only. No running divider sees them until software sets a commit bit. At that moment every legal staged code is copied into the live set in one step. Each divider then changes to its new ratio at the end of the period it is in, so no output ever gives a shortened pulse.

A commit-pending flag reads back as 1 until every divider has taken its new ratio. The divided outputs are registered level signals in the input-clock domain. A register on each output gates it on or off, and that switch is also timed to a period boundary.

Top module: `clkdiv_bank`

## Requirements
- R1: Codes 0..15 select ratios 2, 3, 4, 6, 8, 12, 16, 18, 24, 32, 36, 48, reserved, 72, 96, reserved.
- R2: Word 0 holds the staged codes of outputs 0..4 in bits [23:20], [19:16], [11:8], [7:4] and [3:0]. It reads back the staged codes, and its other bits read 0.
- R3: A write to word 0 only stages codes, and every output keeps its running ratio until a commit.
- R4: Writing word 1 with bit 31 set commits all legal staged codes at once. Each output switches at the end of its current period.
- R5: Word 1 bit 31 reads 1 from the commit until every divider has loaded its new ratio, then clears without any software action.
- R6: Codes 12 and 15 are never applied. On commit, an output whose staged code is 12 or 15 keeps its previous ratio.
- R7: Outputs 0..3 accept codes whose bit is set in 0x6FFF, and output 4 accepts codes whose bit is set in 0x677C. A staged code whose bit is clear is ignored at commit, and that output keeps its ratio.
- R8: For ratio N, each period starts high, with floor(N/2) high cycles followed by ceil(N/2) low cycles.
- R9: Word 1 bits [4:0] enable outputs 0..4. A disabled output stays low. An enable change takes effect only at a period boundary.
- R10: After reset, all codes (staged and live) are 0, the enables are 0, no commit is pending, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write word select (0 codes, 1 control) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 1 | Read word select |
| rd_data_o | output | 32 | Read data (combinational) |
| div_clk_o | output | 5 | Divided clock outputs |

## Verification
The bench builds the bank with its default parameters: five outputs, where outputs 0..3 use mask 0x6FFF and output 4 uses mask 0x677C. With these values one commit can stage a legal code, a reserved code and a mask-rejected code on different outputs at the same time. The long ratios (48, 72, 96) keep the pending flag set across many cycles while short-ratio outputs have already switched.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W    = 32;
  localparam int CODE_W   = 4;
  localparam int CNT_W    = 7;
  localparam int KICK_BIT = 31;
  localparam int MASK_W   = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  ratio_t;

  // Ratio for a code; reserved codes return 0.
  function automatic ratio_t ratio_of(code_t code);
    case (code)
      4'd0:    ratio_of = 7'd2;
      4'd1:    ratio_of = 7'd3;
      4'd2:    ratio_of = 7'd4;
      4'd3:    ratio_of = 7'd6;
      4'd4:    ratio_of = 7'd8;
      4'd5:    ratio_of = 7'd12;
      4'd6:    ratio_of = 7'd16;
      4'd7:    ratio_of = 7'd18;
      4'd8:    ratio_of = 7'd24;
      4'd9:    ratio_of = 7'd32;
      4'd10:   ratio_of = 7'd36;
      4'd11:   ratio_of = 7'd48;
      4'd13:   ratio_of = 7'd72;
      4'd14:   ratio_of = 7'd96;
      default: ratio_of = 7'd0;
    endcase
  endfunction

  // Bit position of each output's code field in word 0.
  function automatic int field_lsb(int idx);
    case (idx)
      0:       field_lsb = 20;
      1:       field_lsb = 16;
      2:       field_lsb = 8;
      3:       field_lsb = 4;
      default: field_lsb = 0;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 5,
  parameter logic [NUM_OUT*MASK_W-1:0] ALLOW_MASKS = '1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          wr_addr_i,
  input  logic [REG_W-1:0]              wr_data_i,
  input  logic                          rd_addr_i,
  output logic [REG_W-1:0]              rd_data_o,
  input  logic                          pend_any_i,
  output logic [NUM_OUT-1:0][CODE_W-1:0] staged_o,
  output logic [NUM_OUT-1:0][CODE_W-1:0] live_o,
  output logic [NUM_OUT-1:0]            en_o,
  output logic                          kick_o
);
  logic [NUM_OUT-1:0][CODE_W-1:0] staged_q, staged_d, live_q, live_d;
  logic [NUM_OUT-1:0]             en_q, en_d, legal_w;
  logic                           wr_codes_w, wr_ctrl_w, kick_w;
  logic [REG_W-1:0]               codes_rd_w, ctrl_rd_w;

  assign wr_codes_w = wr_en_i && !wr_addr_i;
  assign wr_ctrl_w  = wr_en_i &&  wr_addr_i;
  assign kick_w     = wr_ctrl_w && wr_data_i[KICK_BIT];

  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) begin
      legal_w[i] = ALLOW_MASKS[i*MASK_W + int'(staged_q[i])] &&
                   (ratio_of(staged_q[i]) != '0);
    end
  end

  always_comb begin
    staged_d = staged_q;
    live_d   = live_q;
    en_d     = en_q;
    if (wr_codes_w) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        staged_d[i] = wr_data_i[field_lsb(i) +: CODE_W];
      end
    end
    if (wr_ctrl_w) begin
      en_d = wr_data_i[NUM_OUT-1:0];
    end
    if (kick_w) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (legal_w[i]) live_d[i] = staged_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= '0;
      live_q   <= '0;
      en_q     <= '0;
    end else begin
      if (wr_codes_w) staged_q <= staged_d;
      if (kick_w)     live_q   <= live_d;
      if (wr_ctrl_w)  en_q     <= en_d;
    end
  end

  always_comb begin
    codes_rd_w = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      codes_rd_w[field_lsb(i) +: CODE_W] = staged_q[i];
    end
    ctrl_rd_w = '0;
    ctrl_rd_w[KICK_BIT]    = pend_any_i;
    ctrl_rd_w[NUM_OUT-1:0] = en_q;
  end

  assign rd_data_o = rd_addr_i ? ctrl_rd_w : codes_rd_w;
  assign staged_o  = staged_q;
  assign live_o    = live_q;
  assign en_o      = en_q;
  assign kick_o    = kick_w;
endmodule

// File: rtl/clkdiv_unit.sv
module clkdiv_unit
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              en_i,
  input  logic              kick_i,
  output logic              div_o,
  output logic              pend_o
);
  ratio_t ratio_q, ratio_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic run_q, run_d, pend_q, pend_d, out_q, out_d, bound_w;

  always_comb begin
    bound_w = !run_q || (cnt_q == ratio_q - 1'b1);
    if (bound_w) begin
      ratio_d = ratio_of(code_i);
      run_d   = en_i;
      cnt_d   = '0;
    end else begin
      ratio_d = ratio_q;
      run_d   = run_q;
      cnt_d   = cnt_q + 1'b1;
    end
    if (kick_i)       pend_d = 1'b1;
    else if (bound_w) pend_d = 1'b0;
    else              pend_d = pend_q;
    out_d = run_d && (cnt_d < (ratio_d >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= 7'd2;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      pend_q  <= pend_d;
      out_q   <= out_d;
    end
  end

  assign div_o  = out_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 5,
  parameter logic [NUM_OUT*MASK_W-1:0] ALLOW_MASKS =
    {16'h677C, 16'h6FFF, 16'h6FFF, 16'h6FFF, 16'h6FFF}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               rd_addr_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic [NUM_OUT-1:0] div_clk_o
);
  logic [NUM_OUT-1:0][CODE_W-1:0] staged_w, live_w;
  logic [NUM_OUT-1:0]             en_w, pend_w;
  logic                           kick_w, pend_any_w;

  assign pend_any_w = |pend_w;

  clkdiv_regs #(.NUM_OUT(NUM_OUT), .ALLOW_MASKS(ALLOW_MASKS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .pend_any_i (pend_any_w),
    .staged_o   (staged_w),
    .live_o     (live_w),
    .en_o       (en_w),
    .kick_o     (kick_w)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
    clkdiv_unit u_unit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_i (live_w[g]),
      .en_i   (en_w[g]),
      .kick_i (kick_w),
      .div_o  (div_clk_o[g]),
      .pend_o (pend_w[g])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 5,
  parameter logic [NUM_OUT*MASK_W-1:0] ALLOW_MASKS = '1
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           kick_i,
  input logic                           pend_any_i,
  input logic [NUM_OUT-1:0][CODE_W-1:0] staged_i,
  input logic [NUM_OUT-1:0][CODE_W-1:0] live_i
);
  AST_KICK_SETS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> pend_any_i); // R5

  AST_LIVE_ONLY_ON_KICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kick_i |=> $stable(live_i)); // R3

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    AST_LIVE_NOT_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ratio_of(live_i[g]) != '0); // R6

    AST_MASK_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kick_i && !ALLOW_MASKS[g*MASK_W + int'(staged_i[g])]) |=> $stable(live_i[g])); // R7
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_OUT(NUM_OUT), .ALLOW_MASKS(ALLOW_MASKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .kick_i     (kick_w),
  .pend_any_i (pend_any_w),
  .staged_i   (staged_w),
  .live_i     (live_w)
);

// File: tb/clkdiv_bank_test.sv
module clkdiv_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [4:0]  div;

  always #10 clk = ~clk;

  clkdiv_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .div_clk_o(div)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  localparam int POS [5] = '{20, 16, 8, 4, 0};
  localparam int MASK[5] = '{32'h6FFF, 32'h6FFF, 32'h6FFF, 32'h6FFF, 32'h677C};

  function automatic int ratio_tab(int c);
    int t[16] = '{2, 3, 4, 6, 8, 12, 16, 18, 24, 32, 36, 48, 0, 72, 96, 0};
    return t[c];
  endfunction

  function automatic logic [31:0] pack_codes(int c0, int c1, int c2, int c3, int c4);
    logic [31:0] w = '0;
    int cs[5] = '{c0, c1, c2, c3, c4};
    for (int i = 0; i < 5; i++) w[POS[i] +: 4] = cs[i][3:0];
    return w;
  endfunction

  // Behavioural reference model
  int  m_cnt[5], m_rat[5], m_stg[5], m_live[5];
  bit  m_run[5], m_pend[5], m_out[5];
  bit  [4:0] m_en;
  bit  m_kick;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin
        m_cnt[i] = 0; m_rat[i] = 2; m_stg[i] = 0; m_live[i] = 0;
        m_run[i] = 0; m_pend[i] = 0; m_out[i] = 0;
      end
      m_en = '0;
    end else begin
      m_kick = wr_en && wr_addr && wr_data[31];
      for (int i = 0; i < 5; i++) begin
        if (!m_run[i] || m_cnt[i] == m_rat[i] - 1) begin
          m_rat[i] = ratio_tab(m_live[i]);
          m_run[i] = m_en[i];
          m_cnt[i] = 0;
          m_pend[i] = 0;
        end else begin
          m_cnt[i]++;
        end
        if (m_kick) m_pend[i] = 1;
        m_out[i] = m_run[i] && (m_cnt[i] < m_rat[i] / 2);
      end
      if (wr_en && !wr_addr)
        for (int i = 0; i < 5; i++) m_stg[i] = int'(wr_data[POS[i] +: 4]);
      if (wr_en && wr_addr) begin
        m_en = wr_data[4:0];
        if (m_kick)
          for (int i = 0; i < 5; i++)
            if (MASK[i][m_stg[i]] && ratio_tab(m_stg[i]) != 0) m_live[i] = m_stg[i];
      end
    end
  end

  function automatic bit m_pend_any();
    bit p = 0;
    for (int i = 0; i < 5; i++) p |= m_pend[i];
    return p;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle compare of outputs against the model: R4 R8 R9
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [4:0] e;
      for (int i = 0; i < 5; i++) e[i] = m_out[i];
      chk(div === e, "R8 R4 R9 cycle compare", div, e);
    end
  end

  task automatic write_reg(bit a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic chk_rd(bit a, logic [31:0] exp, string tag);
    rd_addr = a;
    #1;
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic wait_idle();
    int n = 0;
    rd_addr = 1;
    do begin
      @(negedge clk); #1;
      chk(rd_data[31] === m_pend_any(), "R5 pending vs model", rd_data[31], m_pend_any());
      n++;
    end while (rd_data[31] && n < 400);
    chk(rd_data[31] === 1'b0, "R5 pending clears", rd_data[31], 0);
  endtask

  task automatic measure(int i, int ehi, int elo, string tag);
    int hi = 0, lo = 0;
    @(negedge clk);
    while (div[i] !== 1'b0) @(negedge clk);
    while (div[i] !== 1'b1) @(negedge clk);
    while (div[i] === 1'b1) begin hi++; @(negedge clk); end
    while (div[i] === 1'b0) begin lo++; @(negedge clk); end
    chk(hi == ehi, tag, hi, ehi);
    chk(lo == elo, tag, lo, elo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = '0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk_rd(0, 32'h0, "R10 codes after reset");
    chk_rd(1, 32'h0, "R10 control after reset");
    chk(div === 5'b0, "R10 outputs low", div, 0);

    // R9 enable all, default ratio 2
    write_reg(1, 32'h0000_001F);
    measure(0, 1, 1, "R1 R8 code 0 ratio 2");

    // R2 R3 stage only
    write_reg(0, pack_codes(1, 3, 11, 12, 0));
    chk_rd(0, pack_codes(1, 3, 11, 12, 0), "R2 field readback");
    measure(0, 1, 1, "R3 staged code not yet applied");

    // R4 R5 commit
    write_reg(1, 32'h8000_001F);
    chk_rd(1, 32'h8000_001F, "R5 pending after commit");
    wait_idle();
    measure(0, 1, 2, "R8 odd ratio 3");
    measure(1, 3, 3, "R1 code 3 ratio 6");
    measure(2, 24, 24, "R1 code 11 ratio 48");
    measure(3, 1, 1, "R6 reserved code 12 ignored");
    measure(4, 1, 1, "R7 code 0 rejected by 0x677C");

    // second commit: long ratios, code 15 reserved
    write_reg(0, pack_codes(14, 3, 11, 15, 13));
    write_reg(1, 32'h8000_001F);
    chk_rd(1, 32'h8000_001F, "R5 pending after second commit");
    wait_idle();
    measure(0, 48, 48, "R1 code 14 ratio 96");
    measure(4, 36, 36, "R7 code 13 accepted on output 4");
    measure(3, 1, 1, "R6 reserved code 15 ignored");

    // mask rejection on output 4 only
    write_reg(0, pack_codes(5, 3, 11, 15, 11));
    write_reg(1, 32'h8000_001F);
    wait_idle();
    measure(0, 6, 6, "R1 code 5 ratio 12");
    measure(4, 36, 36, "R7 code 11 rejected on output 4");

    // R9 disable output 1
    write_reg(1, 32'h0000_001D);
    chk_rd(1, 32'h0000_001D, "R9 enable readback");
    repeat (8) @(negedge clk);
    begin
      int highs = 0;
      repeat (20) begin @(negedge clk); if (div[1] !== 1'b0) highs++; end
      chk(highs == 0, "R9 disabled output stays low", highs, 0);
    end
    measure(2, 24, 24, "R9 other outputs keep running");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule